// File: doc/BRIEF.md
# Zero-Byte Sleep Gating Path

This block sits between the byte-rotation stage of a cache write path and the SRAM data array, and again between the array and the realignment stage on the read path. Each line holds 64 bytes. When a line is written, every byte is tested for the value zero. A zero byte is never stored. Instead, a per-line, per-byte sleep flag records it, and the byte write enable for that position stays low, so that the array can leave those cells powered off. A write of a nonzero byte to a position that was asleep clears its flag and enables the write again, which wakes the position. The test runs on data that has already been rotated, so each flag names a physical byte position.

On a read, the block takes the request, fetches the line's sleep flags, and the following cycle combines them with the array's output. Every sleeping byte is forced to zero, and every awake byte passes through unchanged. The array contents of sleeping positions are never used and may hold any value. A read never clears a sleep flag. After reset every line counts as fully asleep, so a line that has never been written reads as all zeros.

Top module: `zbyte_sleep_path`

## Requirements
- R1: After reset, every sleep flag of every line is set. A read of a line that has not been written returns all zeros whatever the array returns, and arrWrEn and outValid are low.
- R2: A write (wrValid high) drives arrWrIndex equal to wrIndex and arrWrData equal to wrData in the same cycle, with no register on the way.
- R3: During a write, arrByteEn bit i is 1 exactly when byte i of wrData (bits 8i+7 down to 8i) is nonzero. When no write is presented, arrByteEn is all zeros and arrWrEn is low.
- R4: A write whose 64 bytes are all zero leaves arrWrEn low and puts every byte of that line to sleep. A write with at least one nonzero byte raises arrWrEn.
- R5: A read request (rdValid high, rdIndex) raises arrRdEn with arrRdIndex equal to rdIndex in the same cycle. The block samples arrRdData one cycle after the request, and outValid and outData appear two clock edges after the request edge. Requests may be issued back to back, one per cycle.
- R6: In a read result, every byte whose sleep flag is set is 0x00 regardless of arrRdData, and every awake byte equals the corresponding byte of arrRdData.
- R7: Writing a nonzero value to a sleeping byte wakes it: later reads of that line return the array content written there.
- R8: Writing zero to an awake byte puts it to sleep: later reads return 0x00 for it, even though the array still holds older nonzero data in that position.
- R9: A write changes only the sleep flags of the line it addresses.
- R10: A read changes no sleep flag and causes no array write, so repeated reads of a line return the same data.
- R11: outValid is high only in the cycle two edges after an accepted read request.
- R12: When a read and a write address the same line in the same cycle, the read uses the sleep flags from before that write, and the array returns the cells' old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Write request for the rotated line |
| wrIndex | input | 4 | Line index of the write |
| wrData | input | 512 | Rotated write data, 64 bytes |
| arrWrEn | output | 1 | Array write strobe |
| arrWrIndex | output | 4 | Array write line index |
| arrByteEn | output | 64 | Per-byte array write enables |
| arrWrData | output | 512 | Data presented to the array |
| rdValid | input | 1 | Read request |
| rdIndex | input | 4 | Line index of the read |
| arrRdEn | output | 1 | Array read strobe |
| arrRdIndex | output | 4 | Array read line index |
| arrRdData | input | 512 | Array read data, valid the cycle after arrRdEn |
| outValid | output | 1 | Read result valid, toward realignment |
| outData | output | 512 | Read result with sleeping bytes forced to zero |

## Verification
Write-side outputs are combinational, so the bench checks them a couple of nanoseconds after it drives the write, before the next rising edge. Read results are due two edges after the request edge. Each read pushes its expected line and its issue cycle into a queue, and a monitor on the falling edge pops an entry whenever outValid is high. The monitor compares the data and checks that exactly two cycles have passed. An outValid with nothing queued is reported as a failure. The array model fills every byte that is not enabled with random nonzero garbage, so a result that depends on sleeping cells shows up as a data mismatch.

// File: rtl/zsp_pkg.sv
package zsp_pkg;

  localparam int BYTE_W = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrFire;   // write accepted this cycle
    logic rdFire;   // read request accepted this cycle
    logic outLoad;  // array data for the pending read is present
  } ctrlStrobe_t;

endpackage

// File: rtl/zsp_ctrl.sv
module zsp_ctrl
  import zsp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic        rdValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  logic rdPendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPendQ  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      rdPendQ  <= rdValid;
      outValid <= rdPendQ;
    end
  end

  always_comb begin
    strobe.wrFire  = wrValid;
    strobe.rdFire  = rdValid;
    strobe.outLoad = rdPendQ;
  end

endmodule

// File: rtl/zsp_datapath.sv
module zsp_datapath
  import zsp_pkg::*;
#(
  parameter  int LINE_BYTES = 64,
  parameter  int NUM_LINES  = 16,
  localparam int LINE_W     = LINE_BYTES * BYTE_W,
  localparam int IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [IDX_W-1:0]      wrIndex,
  input  logic [LINE_W-1:0]     wrData,
  output logic                  arrWrEn,
  output logic [IDX_W-1:0]      arrWrIndex,
  output logic [LINE_BYTES-1:0] arrByteEn,
  output logic [LINE_W-1:0]     arrWrData,
  input  logic [IDX_W-1:0]      rdIndex,
  output logic                  arrRdEn,
  output logic [IDX_W-1:0]      arrRdIndex,
  input  logic [LINE_W-1:0]     arrRdData,
  output logic [LINE_W-1:0]     outData
);

  logic [LINE_BYTES-1:0] byteNz;
  logic [LINE_BYTES-1:0] sleepMask [NUM_LINES];
  logic [LINE_BYTES-1:0] maskQ;
  logic [LINE_W-1:0]     gated;

  // Zero detection on the physical byte positions
  for (genvar b = 0; b < LINE_BYTES; b++) begin : gZeroDet
    assign byteNz[b] = |wrData[b*BYTE_W +: BYTE_W];
  end

  // Read-side gating: sleeping bytes are forced to zero
  for (genvar b = 0; b < LINE_BYTES; b++) begin : gSleepGate
    assign gated[b*BYTE_W +: BYTE_W] =
      maskQ[b] ? {BYTE_W{1'b0}} : arrRdData[b*BYTE_W +: BYTE_W];
  end

  // Write path toward the array
  always_comb begin
    arrWrEn    = strobe.wrFire & (|byteNz);
    arrByteEn  = strobe.wrFire ? byteNz : '0;
    arrWrIndex = wrIndex;
    arrWrData  = wrData;
    arrRdEn    = strobe.rdFire;
    arrRdIndex = rdIndex;
  end

  // Sleep-mask storage, one flag per byte per line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        sleepMask[l] <= '1;
      end
    end else if (strobe.wrFire) begin
      sleepMask[wrIndex] <= ~byteNz;
    end
  end

  // Read pipeline: flags captured with the request, data one cycle later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '1;
      outData <= '0;
    end else begin
      if (strobe.rdFire) begin
        maskQ <= sleepMask[rdIndex];
      end
      if (strobe.outLoad) begin
        outData <= gated;
      end
    end
  end

endmodule

// File: rtl/zbyte_sleep_path.sv
module zbyte_sleep_path
  import zsp_pkg::*;
#(
  parameter  int LINE_BYTES = 64,
  parameter  int NUM_LINES  = 16,
  localparam int LINE_W     = LINE_BYTES * BYTE_W,
  localparam int IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrValid,
  input  logic [IDX_W-1:0]      wrIndex,
  input  logic [LINE_W-1:0]     wrData,
  output logic                  arrWrEn,
  output logic [IDX_W-1:0]      arrWrIndex,
  output logic [LINE_BYTES-1:0] arrByteEn,
  output logic [LINE_W-1:0]     arrWrData,
  input  logic                  rdValid,
  input  logic [IDX_W-1:0]      rdIndex,
  output logic                  arrRdEn,
  output logic [IDX_W-1:0]      arrRdIndex,
  input  logic [LINE_W-1:0]     arrRdData,
  output logic                  outValid,
  output logic [LINE_W-1:0]     outData
);

  ctrlStrobe_t strobe;

  zsp_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (wrValid),
    .rdValid  (rdValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  zsp_datapath #(
    .LINE_BYTES (LINE_BYTES),
    .NUM_LINES  (NUM_LINES)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrIndex    (wrIndex),
    .wrData     (wrData),
    .arrWrEn    (arrWrEn),
    .arrWrIndex (arrWrIndex),
    .arrByteEn  (arrByteEn),
    .arrWrData  (arrWrData),
    .rdIndex    (rdIndex),
    .arrRdEn    (arrRdEn),
    .arrRdIndex (arrRdIndex),
    .arrRdData  (arrRdData),
    .outData    (outData)
  );

endmodule

// File: rtl/zsp_checker.sv
module zsp_checker
  import zsp_pkg::*;
#(
  parameter  int LINE_BYTES = 64,
  localparam int LINE_W     = LINE_BYTES * BYTE_W
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrValid,
  input logic                  rdValid,
  input logic                  arrWrEn,
  input logic [LINE_BYTES-1:0] arrByteEn,
  input logic [LINE_W-1:0]     arrWrData,
  input logic [LINE_W-1:0]     arrRdData,
  input logic                  outValid,
  input logic [LINE_W-1:0]     outData
);

  // R3
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> (!arrWrEn && arrByteEn == '0));

  // R4
  strobe_has_bytes_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (arrByteEn != '0));

  // R5
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> ##1 outValid);

  // R11
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(rdValid, 2));

  for (genvar b = 0; b < LINE_BYTES; b++) begin : gByteChk
    // R3
    enabled_byte_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
      arrByteEn[b] |-> (arrWrData[b*BYTE_W +: BYTE_W] != '0));

    // R6
    out_byte_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> (outData[b*BYTE_W +: BYTE_W] == '0 ||
                    outData[b*BYTE_W +: BYTE_W] == $past(arrRdData[b*BYTE_W +: BYTE_W])));
  end

endmodule

bind zbyte_sleep_path zsp_checker #(.LINE_BYTES(LINE_BYTES)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrValid   (wrValid),
  .rdValid   (rdValid),
  .arrWrEn   (arrWrEn),
  .arrByteEn (arrByteEn),
  .arrWrData (arrWrData),
  .arrRdData (arrRdData),
  .outValid  (outValid),
  .outData   (outData)
);

// File: tb/tb_zbyte_sleep_path.sv
`timescale 1ns/1ps
module tb_zbyte_sleep_path;

  localparam int NB    = 64;
  localparam int NL    = 16;
  localparam int LW    = NB * 8;
  localparam int IW    = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrValid = 1'b0;
  logic [IW-1:0] wrIndex = '0;
  logic [LW-1:0] wrData = '0;
  logic          arrWrEn;
  logic [IW-1:0] arrWrIndex;
  logic [NB-1:0] arrByteEn;
  logic [LW-1:0] arrWrData;
  logic          rdValid = 1'b0;
  logic [IW-1:0] rdIndex = '0;
  logic          arrRdEn;
  logic [IW-1:0] arrRdIndex;
  logic [LW-1:0] arrRdData = '0;
  logic          outValid;
  logic [LW-1:0] outData;

  always #10 clk = ~clk;  // 50 MHz

  zbyte_sleep_path #(.LINE_BYTES(NB), .NUM_LINES(NL)) dut (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrIndex(wrIndex), .wrData(wrData),
    .arrWrEn(arrWrEn), .arrWrIndex(arrWrIndex), .arrByteEn(arrByteEn), .arrWrData(arrWrData),
    .rdValid(rdValid), .rdIndex(rdIndex),
    .arrRdEn(arrRdEn), .arrRdIndex(arrRdIndex), .arrRdData(arrRdData),
    .outValid(outValid), .outData(outData)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  typedef struct {
    logic [LW-1:0] data;
    int            issueCyc;
    string         tag;
  } rdItem_t;

  rdItem_t       expQ[$];
  logic [LW-1:0] expLine [NL];  // expected read result per line
  logic [LW-1:0] cells   [NL];  // modelled array contents

  function automatic logic [7:0] garbage();
    return 8'($urandom) | 8'h01;
  endfunction

  function automatic logic [LW-1:0] mkLine(int zeroPct);
    logic [LW-1:0] v;
    for (int b = 0; b < NB; b++) begin
      if (int'($urandom % 100) < zeroPct) v[b*8 +: 8] = 8'h00;
      else                                v[b*8 +: 8] = garbage();
    end
    return v;
  endfunction

  function automatic logic [NB-1:0] nzMask(logic [LW-1:0] v);
    logic [NB-1:0] m;
    for (int b = 0; b < NB; b++) m[b] = (v[b*8 +: 8] != 8'h00);
    return m;
  endfunction

  task automatic check(string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Array model: synchronous read (old data on collision), byte-enabled write.
  // Cells of bytes not written get random garbage, standing in for powered-off storage.
  always @(posedge clk) begin
    if (arrRdEn) arrRdData <= cells[arrRdIndex];
    if (arrWrEn) begin
      for (int b = 0; b < NB; b++) begin
        if (arrByteEn[b]) cells[arrWrIndex][b*8 +: 8] <= arrWrData[b*8 +: 8];
        else              cells[arrWrIndex][b*8 +: 8] <= garbage();
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected read results as they emerge
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        nChecks++;
        nFails++;
        $display("FAIL R11 outValid with no read pending: actual 1 expected 0");
      end else begin
        rdItem_t it;
        it = expQ.pop_front();
        check(it.tag, "read data (R6)", outData, it.data);
        check("R5", "read latency", LW'(cyc - it.issueCyc), LW'(2));
      end
    end
  end

  task automatic doWrite(int idx, logic [LW-1:0] data, string tag);
    wrValid = 1'b1;
    wrIndex = IW'(idx);
    wrData  = data;
    #2;
    check("R2", {tag, " arrWrIndex"}, LW'(arrWrIndex), LW'(idx));
    check("R2", {tag, " arrWrData"}, arrWrData, data);
    check("R3", {tag, " arrByteEn"}, LW'(arrByteEn), LW'(nzMask(data)));
    check("R4", {tag, " arrWrEn"}, LW'(arrWrEn), LW'(data != '0));
    @(negedge clk);
    wrValid = 1'b0;
    expLine[idx] = data;
  endtask

  task automatic doRead(int idx, string tag);
    rdItem_t it;
    rdValid = 1'b1;
    rdIndex = IW'(idx);
    it.data = expLine[idx];
    it.issueCyc = cyc;
    it.tag = tag;
    expQ.push_back(it);
    #2;
    check("R5", "arrRdEn", LW'(arrRdEn), LW'(1));
    check("R5", "arrRdIndex", LW'(arrRdIndex), LW'(idx));
    check("R10", "no array write during read", LW'(arrWrEn), LW'(0));
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [LW-1:0] d;
    for (int l = 0; l < NL; l++) begin
      expLine[l] = '0;
      for (int b = 0; b < NB; b++) cells[l][b*8 +: 8] = garbage();
    end

    repeat (3) @(negedge clk);
    check("R1", "arrWrEn in reset", LW'(arrWrEn), LW'(0));
    check("R1", "outValid in reset", LW'(outValid), LW'(0));
    rstN = 1'b1;
    @(negedge clk);

    // R1: unwritten lines read as zero despite garbage cells
    doRead(0, "R1");
    doRead(5, "R1");
    doRead(15, "R1");
    drain();

    // R3/R6: mixed zero and nonzero bytes
    doWrite(3, mkLine(50), "R3 mixed");
    doRead(3, "R6");
    drain();

    // R4/R8: all-zero write puts every awake byte to sleep
    doWrite(3, '0, "R4 all-zero");
    doRead(3, "R8");
    drain();

    // R7: nonzero bytes wake every sleeping position
    doWrite(3, mkLine(0), "R7 full");
    doRead(3, "R7");
    drain();

    // R8: single zero byte in an otherwise awake line
    d = expLine[3];
    d[17*8 +: 8] = 8'h00;
    doWrite(3, d, "R8 one-zero");
    doRead(3, "R8");
    drain();

    // R9: another line written, line 3 keeps its flags
    doWrite(7, mkLine(30), "R9 other");
    doRead(3, "R9");
    doRead(7, "R9");
    drain();

    // R10/R5: back-to-back reads of one line
    doRead(3, "R10");
    doRead(3, "R10");
    doRead(3, "R10");
    drain();

    // R12: read and write of the same line in one cycle
    begin
      rdItem_t it;
      d = mkLine(50);
      it.data = expLine[9];
      it.issueCyc = cyc;
      it.tag = "R12";
      expQ.push_back(it);
      rdValid = 1'b1;
      rdIndex = IW'(9);
      wrValid = 1'b1;
      wrIndex = IW'(9);
      wrData  = d;
      @(negedge clk);
      rdValid = 1'b0;
      wrValid = 1'b0;
      expLine[9] = d;
      doRead(9, "R12 after");
      drain();
    end

    // Random mix of writes and reads
    for (int i = 0; i < 60; i++) begin
      int idx;
      idx = int'($urandom % NL);
      if ($urandom % 2 == 0) doWrite(idx, mkLine(int'($urandom % 101)), "R3 random");
      else                   doRead(idx, "R6 random");
    end
    drain();
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule